// File: doc/BRIEF.md
# CAN Mailbox Interrupt Flag Unit

This block keeps the per-mailbox event flags of a 32-mailbox CAN controller and turns them into summary interrupt-request bits. The message handler sends it single-cycle event pulses, one bit per mailbox, for five events: data frame received, remote frame received, overrun/overwrite, transmit success and transmit abort. A direction input marks each mailbox as receive or transmit. The block updates its pending flags and its acknowledge flags from these pulses. Software reaches every flag register, and the two 16-bit halves of the mailbox interrupt mask, through a small register bus.

The mask only blocks the summary bits. Pending flags, acknowledge flags and the transmit and cancel request bits change on every event, whether the mailbox is masked or not. A summary bit is set only by an event that arrives while its mailbox is unmasked and has the matching direction. Summary bits are sticky, and software clears them by writing 1. The combined interrupt line is high while any summary bit is set.

Top module: `can_mb_irq_flags`

## Requirements
- R1: The mask lives at address 0 (mailboxes 15..0, bit n = mailbox n) and address 1 (mailboxes 31..16, bit n = mailbox n+16). A write stores the data and a read returns it. After reset both halves read 0xFFFF.
- R2: The summary register is at address 16. Bit 1 means data received, bit 2 remote frame received, bit 8 mailbox empty and bit 9 overwrite. Every other bit reads 0. The register resets to 0, and `irq_o` is high exactly while any summary bit is set.
- R3: A data, remote or overrun event on a receive mailbox whose mask bit is 0 sets summary bit 1, 2 or 9 on the next clock edge.
- R4: Data, remote and overrun events set the mailbox's pending bit on the next edge, whatever the mask and the direction. The pending registers sit at address 2/3 (data), 4/5 (remote) and 6/7 (overwrite), each split low half then high half.
- R5: An event on a masked mailbox leaves the summary bits unchanged.
- R6: A transmit-success event clears the mailbox's transmit-request bit (address 8/9) and its cancel-request bit (address 10/11), and sets its transmit-acknowledge bit (address 12/13), whatever the mask. On an unmasked transmit mailbox it also sets summary bit 8.
- R7: A transmit-abort event clears the mailbox's transmit-request and cancel-request bits and sets its abort-acknowledge bit (address 14/15), whatever the mask. It sets summary bit 8 only when the mailbox is unmasked.
- R8: The pending, acknowledge and summary bits clear when 1 is written to them. Writing 0 leaves them as they are.
- R9: When a hardware event sets a flag in the same cycle as a software write of 1 that clears it, the flag ends up set.
- R10: Clearing a mask bit while that mailbox's pending flag is already set does not set any summary bit.
- R11: Writing 1 sets transmit-request and cancel-request bits. Writing 0 leaves them as they are.
- R12: Summary bits follow the direction input (`mb_is_rx` bit = 1 for receive). Receive events on a transmit mailbox, and transmit events on a receive mailbox, set no summary bit, but their flags still update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| mb_is_rx | input | 32 | Direction per mailbox, 1 = receive |
| ev_rx_data | input | 32 | Data frame received, per mailbox |
| ev_rx_remote | input | 32 | Remote frame received, per mailbox |
| ev_overrun | input | 32 | Overrun/overwrite, per mailbox |
| ev_tx_done | input | 32 | Transmission completed, per mailbox |
| ev_tx_abort | input | 32 | Transmission aborted, per mailbox |
| irq_summary | output | 16 | Summary interrupt-request bits |
| irq_o | output | 1 | OR of all summary bits |

## Verification
The hardest case to reach from the ports is a hardware set and a software write-1 clear landing on the same flag in the same cycle. The bench has a combined task that drives an event pulse and a bus write at one falling edge, so both reach the same rising edge. It does this once for a summary bit and once for an acknowledge register, and in each case reads back which of the two won. Masked events, direction mismatches and late unmasking each get a pulse of their own, and the bench then reads the summary register and the pending flag for that pulse.

// File: rtl/mbif_pkg.sv
package mbif_pkg;
    localparam int MB_N   = 32;
    localparam int HALF_W = 16;
    localparam int N_HALF = MB_N / HALF_W;
    localparam int ADDR_W = 5;

    typedef logic [MB_N-1:0]   mb_vec_t;
    typedef logic [HALF_W-1:0] half_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        FLAG_W1C,   // hardware sets, software writes 1 to clear
        FLAG_W1S,   // software writes 1 to set, hardware clears
        FLAG_RW     // plain read/write
    } flag_kind_e;

    typedef struct packed {
        logic  wr;
        addr_t addr;
        half_t wdata;
    } bus_req_t;

    // register map, each flag register occupies BASE (low half) and BASE+1 (high half)
    localparam addr_t A_MASK   = 5'd0;
    localparam addr_t A_RXD    = 5'd2;
    localparam addr_t A_RMT    = 5'd4;
    localparam addr_t A_OVW    = 5'd6;
    localparam addr_t A_TXREQ  = 5'd8;
    localparam addr_t A_CANREQ = 5'd10;
    localparam addr_t A_TXACK  = 5'd12;
    localparam addr_t A_ABACK  = 5'd14;
    localparam addr_t A_SUMM   = 5'd16;

    // summary bit positions decoded by the interrupt controller
    localparam int S_RXD   = 1;
    localparam int S_RMT   = 2;
    localparam int S_EMPTY = 8;
    localparam int S_OVW   = 9;

    localparam half_t SUMM_IMPL = half_t'((1 << S_RXD) | (1 << S_RMT) | (1 << S_EMPTY) | (1 << S_OVW));

    typedef struct packed {
        logic ovw;
        logic empty;
        logic rmt;
        logic rxd;
    } sum_set_t;

    function automatic half_t pick_half(input mb_vec_t v, input logic hi);
        return hi ? v[MB_N-1:HALF_W] : v[HALF_W-1:0];
    endfunction

    function automatic half_t sum_vec(input sum_set_t s);
        half_t r;
        r = '0;
        r[S_RXD]   = s.rxd;
        r[S_RMT]   = s.rmt;
        r[S_EMPTY] = s.empty;
        r[S_OVW]   = s.ovw;
        return r;
    endfunction
endpackage

// File: rtl/mbif_flag_bank.sv
module mbif_flag_bank
    import mbif_pkg::*;
#(
    parameter flag_kind_e KIND    = FLAG_W1C,
    parameter addr_t      BASE    = '0,
    parameter mb_vec_t    RST_VAL = '0
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    input  mb_vec_t  hw_set,
    input  mb_vec_t  hw_clr,
    output mb_vec_t  q
);
    mb_vec_t sw_ones;
    mb_vec_t sw_load;
    mb_vec_t d;

    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        logic hit;
        assign hit = req.wr && (req.addr == addr_t'(int'(BASE) + h));
        assign sw_ones[h*HALF_W +: HALF_W] = hit ? req.wdata : '0;
        assign sw_load[h*HALF_W +: HALF_W] = {HALF_W{hit}};
    end

    if (KIND == FLAG_W1C) begin : g_w1c
        // hardware set applied last so it wins over a write-1 clear
        assign d = ((q & ~sw_ones) & ~hw_clr) | hw_set;
    end else if (KIND == FLAG_W1S) begin : g_w1s
        assign d = ((q | sw_ones) | hw_set) & ~hw_clr;
    end else begin : g_rw
        assign d = (((sw_load & sw_ones) | (~sw_load & q)) & ~hw_clr) | hw_set;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL;
        else     q <= d;
    end

    if (KIND == FLAG_W1C) begin : g_chk_w1c
        // R9: a hardware set is visible next cycle even under a write-1 clear
        a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
            (|hw_set) |=> ((q & $past(hw_set)) == $past(hw_set)));
        // R8: bits neither set nor written stay unchanged
        a_r8_hold: assert property (@(posedge clk) disable iff (rst)
            (!req.wr && hw_set == '0 && hw_clr == '0) |=> $stable(q));
    end else if (KIND == FLAG_W1S) begin : g_chk_w1s
        // R6 / R7: completion or abort clears the request bit
        a_r6_hw_clear: assert property (@(posedge clk) disable iff (rst)
            (|hw_clr) |=> ((q & $past(hw_clr)) == '0));
        // R11: a write never drops a bit the hardware did not clear
        a_r11_no_drop: assert property (@(posedge clk) disable iff (rst)
            (hw_clr == '0) |=> ((q & $past(q)) == $past(q)));
    end else begin : g_chk_rw
        // R1: the low-half write lands when no hardware term touches it
        a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
            (req.wr && req.addr == BASE && hw_set == '0 && hw_clr == '0)
            |=> (q[HALF_W-1:0] == $past(req.wdata)));
    end
endmodule

// File: rtl/mbif_summary.sv
module mbif_summary
    import mbif_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    input  mb_vec_t  mb_is_rx,
    input  mb_vec_t  mask,
    input  mb_vec_t  ev_rx_data,
    input  mb_vec_t  ev_rx_remote,
    input  mb_vec_t  ev_overrun,
    input  mb_vec_t  ev_tx_done,
    input  mb_vec_t  ev_tx_abort,
    output half_t    summ,
    output logic     irq
);
    mb_vec_t  rx_ok;
    mb_vec_t  tx_ok;
    sum_set_t set_s;
    half_t    set_v;
    half_t    clr_v;

    assign rx_ok = mb_is_rx & ~mask;
    assign tx_ok = ~mb_is_rx & ~mask;

    always_comb begin
        set_s.rxd   = |(ev_rx_data   & rx_ok);
        set_s.rmt   = |(ev_rx_remote & rx_ok);
        set_s.ovw   = |(ev_overrun   & rx_ok);
        set_s.empty = |((ev_tx_done | ev_tx_abort) & tx_ok);
    end

    assign set_v = sum_vec(set_s);
    assign clr_v = (req.wr && req.addr == A_SUMM) ? (req.wdata & SUMM_IMPL) : '0;

    always_ff @(posedge clk) begin
        if (rst) summ <= '0;
        else     summ <= (summ & ~clr_v) | set_v;
    end

    assign irq = |summ;

    // R3: an unmasked receive event raises its summary bit
    a_r3_rx_raise: assert property (@(posedge clk) disable iff (rst)
        (|(ev_rx_data & mb_is_rx & ~mask)) |=> summ[S_RXD]);
    // R5 / R12: no qualifying event and no prior bit keeps the bit low
    a_r5_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (!summ[S_RXD] && ((ev_rx_data & mb_is_rx & ~mask) == '0)) |=> !summ[S_RXD]);
    // R7: no unmasked transmit-side event keeps the empty bit low
    a_r7_empty_quiet: assert property (@(posedge clk) disable iff (rst)
        (!summ[S_EMPTY] && (((ev_tx_done | ev_tx_abort) & ~mb_is_rx & ~mask) == '0))
        |=> !summ[S_EMPTY]);
    // R2: unimplemented positions never hold a 1
    a_r2_unused_zero: assert property (@(posedge clk) disable iff (rst)
        (summ & ~SUMM_IMPL) == '0);
endmodule

// File: rtl/can_mb_irq_flags.sv
module can_mb_irq_flags
    import mbif_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic [31:0] mb_is_rx,
    input  logic [31:0] ev_rx_data,
    input  logic [31:0] ev_rx_remote,
    input  logic [31:0] ev_overrun,
    input  logic [31:0] ev_tx_done,
    input  logic [31:0] ev_tx_abort,
    output logic [15:0] irq_summary,
    output logic        irq_o
);
    bus_req_t req;
    mb_vec_t  mask_q, rxd_q, rmt_q, ovw_q, txreq_q, canreq_q, txack_q, aback_q;
    mb_vec_t  tx_end;

    assign req    = '{wr: reg_wr, addr: reg_addr, wdata: reg_wdata};
    assign tx_end = ev_tx_done | ev_tx_abort;

    mbif_flag_bank #(.KIND(FLAG_RW),  .BASE(A_MASK),   .RST_VAL('1)) u_mask (
        .clk(clk), .rst(rst), .req(req), .hw_set('0), .hw_clr('0), .q(mask_q));
    mbif_flag_bank #(.KIND(FLAG_W1C), .BASE(A_RXD),    .RST_VAL('0)) u_rxd (
        .clk(clk), .rst(rst), .req(req), .hw_set(ev_rx_data), .hw_clr('0), .q(rxd_q));
    mbif_flag_bank #(.KIND(FLAG_W1C), .BASE(A_RMT),    .RST_VAL('0)) u_rmt (
        .clk(clk), .rst(rst), .req(req), .hw_set(ev_rx_remote), .hw_clr('0), .q(rmt_q));
    mbif_flag_bank #(.KIND(FLAG_W1C), .BASE(A_OVW),    .RST_VAL('0)) u_ovw (
        .clk(clk), .rst(rst), .req(req), .hw_set(ev_overrun), .hw_clr('0), .q(ovw_q));
    mbif_flag_bank #(.KIND(FLAG_W1S), .BASE(A_TXREQ),  .RST_VAL('0)) u_txreq (
        .clk(clk), .rst(rst), .req(req), .hw_set('0), .hw_clr(tx_end), .q(txreq_q));
    mbif_flag_bank #(.KIND(FLAG_W1S), .BASE(A_CANREQ), .RST_VAL('0)) u_canreq (
        .clk(clk), .rst(rst), .req(req), .hw_set('0), .hw_clr(tx_end), .q(canreq_q));
    mbif_flag_bank #(.KIND(FLAG_W1C), .BASE(A_TXACK),  .RST_VAL('0)) u_txack (
        .clk(clk), .rst(rst), .req(req), .hw_set(ev_tx_done), .hw_clr('0), .q(txack_q));
    mbif_flag_bank #(.KIND(FLAG_W1C), .BASE(A_ABACK),  .RST_VAL('0)) u_aback (
        .clk(clk), .rst(rst), .req(req), .hw_set(ev_tx_abort), .hw_clr('0), .q(aback_q));

    mbif_summary u_summ (
        .clk(clk), .rst(rst), .req(req),
        .mb_is_rx(mb_is_rx), .mask(mask_q),
        .ev_rx_data(ev_rx_data), .ev_rx_remote(ev_rx_remote), .ev_overrun(ev_overrun),
        .ev_tx_done(ev_tx_done), .ev_tx_abort(ev_tx_abort),
        .summ(irq_summary), .irq(irq_o));

    always_comb begin
        logic hi;
        hi = reg_addr[0];
        unique case ({reg_addr[4:1], 1'b0})
            A_MASK:   reg_rdata = pick_half(mask_q, hi);
            A_RXD:    reg_rdata = pick_half(rxd_q, hi);
            A_RMT:    reg_rdata = pick_half(rmt_q, hi);
            A_OVW:    reg_rdata = pick_half(ovw_q, hi);
            A_TXREQ:  reg_rdata = pick_half(txreq_q, hi);
            A_CANREQ: reg_rdata = pick_half(canreq_q, hi);
            A_TXACK:  reg_rdata = pick_half(txack_q, hi);
            A_ABACK:  reg_rdata = pick_half(aback_q, hi);
            A_SUMM:   reg_rdata = hi ? '0 : irq_summary;
            default:  reg_rdata = '0;
        endcase
    end

    // R10: without events or a summary write, mask changes leave the summary alone
    a_r10_no_late_raise: assert property (@(posedge clk) disable iff (rst)
        ((ev_rx_data | ev_rx_remote | ev_overrun | ev_tx_done | ev_tx_abort) == '0
         && !(reg_wr && reg_addr == A_SUMM)) |=> $stable(irq_summary));
    // R2: the combined line follows the summary register
    a_r2_irq_follows: assert property (@(posedge clk) disable iff (rst)
        (irq_summary == '0) |-> !irq_o);
endmodule

// File: tb/can_mb_irq_flags_tb.sv
module can_mb_irq_flags_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [31:0] mb_is_rx = 32'h0000_FFFF;
    logic [31:0] ev_rx_data = '0, ev_rx_remote = '0, ev_overrun = '0;
    logic [31:0] ev_tx_done = '0, ev_tx_abort = '0;
    logic [15:0] irq_summary;
    logic        irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_mb_irq_flags u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mb_is_rx(mb_is_rx),
        .ev_rx_data(ev_rx_data), .ev_rx_remote(ev_rx_remote), .ev_overrun(ev_overrun),
        .ev_tx_done(ev_tx_done), .ev_tx_abort(ev_tx_abort),
        .irq_summary(irq_summary), .irq_o(irq_o));

    typedef struct packed {
        logic        rd;
        logic [4:0]  addr;
        logic [15:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 5'd0,  16'hFFFF, 8'd1},   // R1 reset value low
        '{1'b1, 5'd1,  16'hFFFF, 8'd1},   // R1 reset value high
        '{1'b1, 5'd16, 16'h0000, 8'd2},   // R2 summary reset
        '{1'b0, 5'd0,  16'h00F0, 8'd1},
        '{1'b1, 5'd0,  16'h00F0, 8'd1},   // R1
        '{1'b0, 5'd1,  16'h8001, 8'd1},
        '{1'b1, 5'd1,  16'h8001, 8'd1},   // R1
        '{1'b0, 5'd8,  16'h0005, 8'd11},
        '{1'b0, 5'd8,  16'h0000, 8'd11},
        '{1'b1, 5'd8,  16'h0005, 8'd11},  // R11 zero write keeps bits
        '{1'b0, 5'd11, 16'h0100, 8'd11},
        '{1'b1, 5'd11, 16'h0100, 8'd11},  // R11
        '{1'b0, 5'd2,  16'hFFFF, 8'd8},
        '{1'b1, 5'd2,  16'h0000, 8'd8}    // R8 clearing clear bits
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rdchk(input logic [4:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    // one cycle of events, optionally with a bus write in the same cycle
    task automatic pulse(input logic [31:0] rxd, rmt, ovw, tdn, tab,
                         input logic w, input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        ev_rx_data = rxd; ev_rx_remote = rmt; ev_overrun = ovw;
        ev_tx_done = tdn; ev_tx_abort = tab;
        reg_wr = w; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        ev_rx_data = '0; ev_rx_remote = '0; ev_overrun = '0;
        ev_tx_done = '0; ev_tx_abort = '0; reg_wr = 1'b0;
    endtask

    task automatic summary_line();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary_line();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R2 irq after reset", {15'b0, irq_o}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            if (TBL[i].rd)
                rdchk(TBL[i].addr, TBL[i].data, $sformatf("R%0d table entry %0d", TBL[i].req, i));
            else
                wr(TBL[i].addr, TBL[i].data);
        end

        // R3 / R4: unmasked receive mailbox 0
        pulse(32'h1, '0, '0, '0, '0, 1'b0, 5'd0, '0);
        rdchk(5'd16, 16'h0002, "R3 data summary");
        chk("R2 irq high", {15'b0, irq_o}, 16'h0001);
        rdchk(5'd2, 16'h0001, "R4 data pending");
        wr(5'd16, 16'h0002);
        rdchk(5'd16, 16'h0000, "R8 summary w1c");
        chk("R2 irq low", {15'b0, irq_o}, 16'h0000);
        wr(5'd2, 16'h0001);
        rdchk(5'd2, 16'h0000, "R8 pending w1c");

        // R5: masked mailbox 4
        pulse(32'h10, '0, '0, '0, '0, 1'b0, 5'd0, '0);
        rdchk(5'd16, 16'h0000, "R5 masked no summary");
        rdchk(5'd2, 16'h0010, "R4 pending despite mask");

        // R10: unmask with pending already set
        wr(5'd0, 16'h0000);
        rdchk(5'd16, 16'h0000, "R10 no late raise");
        chk("R10 irq low", {15'b0, irq_o}, 16'h0000);

        // R3: remote and overwrite
        pulse('0, 32'h4, '0, '0, '0, 1'b0, 5'd0, '0);
        rdchk(5'd16, 16'h0004, "R3 remote summary");
        rdchk(5'd4, 16'h0004, "R4 remote pending");
        wr(5'd16, 16'h0004);
        pulse('0, '0, 32'h8, '0, '0, 1'b0, 5'd0, '0);
        rdchk(5'd16, 16'h0200, "R3 overwrite summary");
        rdchk(5'd6, 16'h0008, "R4 overwrite flag");
        wr(5'd16, 16'h0200);

        // R12: receive event on transmit mailbox 20
        pulse(32'h0010_0000, '0, '0, '0, '0, 1'b0, 5'd0, '0);
        rdchk(5'd16, 16'h0000, "R12 rx on tx mailbox");
        rdchk(5'd3, 16'h0010, "R12 pending still set");

        // R6: transmit success on mailboxes 17 and 18
        wr(5'd9, 16'h0006);
        wr(5'd11, 16'h0004);
        pulse('0, '0, '0, 32'h0006_0000, '0, 1'b0, 5'd0, '0);
        rdchk(5'd9, 16'h0000, "R6 txreq cleared");
        rdchk(5'd11, 16'h0100, "R6 cancel cleared");
        rdchk(5'd13, 16'h0006, "R6 tx ack set");
        rdchk(5'd16, 16'h0100, "R6 empty summary");
        wr(5'd16, 16'h0100);

        // R7: masked abort on mailbox 16
        wr(5'd9, 16'h0001);
        pulse('0, '0, '0, '0, 32'h0001_0000, 1'b0, 5'd0, '0);
        rdchk(5'd9, 16'h0000, "R7 txreq cleared masked");
        rdchk(5'd15, 16'h0001, "R7 abort ack masked");
        rdchk(5'd16, 16'h0000, "R7 masked no summary");

        // R7: unmasked abort on mailbox 24
        pulse('0, '0, '0, '0, 32'h0100_0000, 1'b0, 5'd0, '0);
        rdchk(5'd11, 16'h0000, "R7 cancel cleared");
        rdchk(5'd15, 16'h0101, "R7 abort ack");
        rdchk(5'd16, 16'h0100, "R7 empty summary");

        // R9: set and write-1 clear in the same cycle
        pulse('0, '0, '0, 32'h0008_0000, '0, 1'b1, 5'd16, 16'h0100);
        rdchk(5'd16, 16'h0100, "R9 summary set wins");
        rdchk(5'd13, 16'h000E, "R9 ack accumulated");
        pulse('0, '0, '0, 32'h0002_0000, '0, 1'b1, 5'd13, 16'h000E);
        rdchk(5'd13, 16'h0002, "R9 ack set wins");

        // R8: zero write has no effect, then clear
        wr(5'd16, 16'h0000);
        rdchk(5'd16, 16'h0100, "R8 zero write");
        wr(5'd16, 16'h0100);
        rdchk(5'd16, 16'h0000, "R8 summary cleared");

        // R12: transmit event on receive mailbox 1
        pulse('0, '0, '0, 32'h2, '0, 1'b0, 5'd0, '0);
        rdchk(5'd16, 16'h0000, "R12 tx on rx mailbox");
        rdchk(5'd12, 16'h0002, "R12 ack still set");
        rdchk(5'd8, 16'h0005, "R11 other requests kept");
        rdchk(5'd17, 16'h0000, "R2 unused address");

        done = 1;
        summary_line();
        $finish;
    end
endmodule